// File: doc/BRIEF.md
# Numeric Node Rewrite Unit

This block performs the local rewrite for interaction-graph node pairs that involve numbers. A scheduler hands it one active pair at a time: two node records together with the memory slots they occupy. The block works out which rule applies and produces write instructions for a later scatter stage. Each instruction is a slot address and a replacement node, and the replacement may be the empty node. The rules handled are two-operand addition and multiplication, the zero test, reading a value from an external key source, and sending a value to an external screen.

Addition and multiplication are split across two separate interactions. The first time an operator node meets a number, it records that fact in a one-bit state held in its kind code, and it exchanges its principal and second auxiliary links. The next interaction then brings the second operand. At that point the block fetches the first operand through a synchronous lookup port and writes out the result. The two operand slots and the operator's own slot are rewritten over two consecutive output beats.

Top module: `num_node_rewriter`

## Requirements
- R1: After reset, every output strobe is low: `busy`, `done`, `err`, `wr0Vld`, `wr1Vld`, `lookupRd`, `keyReq` and `scrFire`.
- R2: A node is packed from MSB to LSB as {kind[3:0], addrFlag, prin[W], aux1[W], aux2[W]}. The kind codes are: empty 0, number 1, add-first 2, add-second 3, mul-first 4, mul-second 5, zero-test 6, key 7, screen 8, eraser 9. Any other code is unsupported. A number has addrFlag 0 and holds its value in aux2. The empty node is all zeros. The result does not depend on which of `nodeA` and `nodeB` holds which member of the pair.
- R3: An add-first or mul-first node meeting a number produces exactly one instruction, at the operator's slot. That instruction holds the matching second-state kind (3 or 5) with addrFlag 1, prin equal to the old aux2, aux1 unchanged, and aux2 equal to the old prin. `done` rises in the same cycle.
- R4: An add-second or mul-second node meeting a number pulses `lookupRd` for one cycle, with `lookupAddr` set to the operator's aux2 (link names index the lookup port directly). The block samples `lookupNode` one cycle later. In the first output beat, wr0 writes, at the operator's slot, a number whose prin is the operator's aux1 and whose value is (looked-up value op partner value) mod 2^W, and wr1 empties the partner's slot. In the next cycle, wr0 empties the slot named by the operator's aux2 and `done` rises.
- R5: If the looked-up node is not a number, the pair raises `err` and `done` and produces no instructions.
- R6: A zero-test node meeting number v writes an eraser (prin set to the unused branch, all other fields 0) at its own slot. At the partner slot it writes a number with prin set to the chosen branch and value v. The chosen branch is aux1 when v is 0 and aux2 otherwise.
- R7: A key node meeting an operator, zero-test or screen node holds `keyReq` high until `keyValid` is sampled. It then writes, at the key's slot, a number with the key's prin and value `keyData`. The partner's slot is not written.
- R8: A screen node meeting a number pulses `scrFire` for one cycle with `scrValue` equal to the number. In that same cycle it empties both slots, the screen slot on wr0 and the number slot on wr1.
- R9: A pair that matches no rule raises `err` together with `done` and writes nothing. This covers two numbers, a number with addrFlag 1, and a key meeting a number.
- R10: A `start` while `busy` is ignored, so the pair in progress completes unchanged.
- R11: Every accepted pair produces exactly one single-cycle `done` pulse, and `wr1Vld` is never high without `wr0Vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the pair on the node inputs |
| nodeA | input | NW | First node of the pair |
| addrA | input | W | Slot of nodeA |
| nodeB | input | NW | Second node of the pair |
| addrB | input | W | Slot of nodeB |
| busy | output | 1 | Pair in progress |
| lookupRd | output | 1 | Lookup request |
| lookupAddr | output | W | Link name to read |
| lookupNode | input | NW | Node returned one cycle after the request |
| keyReq | output | 1 | Waiting for an external value |
| keyValid | input | 1 | External value present |
| keyData | input | W | External value |
| scrFire | output | 1 | Pixel-change event |
| scrValue | output | W | Pixel-change value |
| wr0Vld | output | 1 | Instruction 0 valid |
| wr0Addr | output | W | Instruction 0 slot |
| wr0Node | output | NW | Instruction 0 replacement node |
| wr1Vld | output | 1 | Instruction 1 valid |
| wr1Addr | output | W | Instruction 1 slot |
| wr1Node | output | NW | Instruction 1 replacement node |
| done | output | 1 | Pair finished |
| err | output | 1 | Pair had no rule |

## Verification
The properties assume that the lookup source answers in the cycle after `lookupRd` and holds its answer steady until that answer is sampled. They also assume that `keyValid` appears only while `keyReq` is high. The bench models both ports inside the task that drives each pair, so neither assumption is broken. The bench sets a start pulse while busy only in the dedicated R10 case, and all link and slot fields stay within the configured width of 4 bits.

// File: rtl/numrw_pkg.sv
package numrw_pkg;
  typedef enum logic [3:0] {
    K_EMPTY = 4'd0, K_NUM = 4'd1, K_ADD0 = 4'd2, K_ADD1 = 4'd3, K_MUL0 = 4'd4,
    K_MUL1 = 4'd5, K_IF0 = 4'd6, K_KEY = 4'd7, K_SCR = 4'd8, K_ERA = 4'd9
  } kind_e;

  typedef enum logic [2:0] {C_ERR, C_ALU0, C_ALU1, C_IF0, C_SCR, C_KEY} pair_e;

  typedef enum logic [2:0] {S_IDLE, S_DECODE, S_LOOK, S_LWAIT, S_KEYW, S_EMIT, S_TAIL} state_e;

  typedef struct packed {
    logic loadPair;
    logic loadArg;
    logic loadKey;
    logic emit;
    logic emitTail;
  } strobe_t;
endpackage

// File: rtl/numrw_ctrl.sv
module numrw_ctrl
  import numrw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  pair_e   cls,
  input  logic    argOk,
  input  logic    keyValid,
  output strobe_t stb,
  output logic    busy,
  output logic    lookupRd,
  output logic    keyReq,
  output logic    scrFire,
  output logic    done,
  output logic    err
);
  state_e state, stateNext;
  logic   emitBad;

  assign emitBad = (cls == C_ERR) || (cls == C_ALU1 && !argOk);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      S_IDLE:   if (start) begin stb.loadPair = 1'b1; stateNext = S_DECODE; end
      S_DECODE: begin
        if (cls == C_ALU1)     stateNext = S_LOOK;
        else if (cls == C_KEY) stateNext = S_KEYW;
        else                   stateNext = S_EMIT;
      end
      S_LOOK:   stateNext = S_LWAIT;
      S_LWAIT:  begin stb.loadArg = 1'b1; stateNext = S_EMIT; end
      S_KEYW:   if (keyValid) begin stb.loadKey = 1'b1; stateNext = S_EMIT; end
      S_EMIT:   begin
        stb.emit  = !emitBad;
        stateNext = (cls == C_ALU1 && !emitBad) ? S_TAIL : S_IDLE;
      end
      S_TAIL:   begin stb.emitTail = 1'b1; stateNext = S_IDLE; end
      default:  stateNext = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign lookupRd = (state == S_LOOK);
  assign keyReq   = (state == S_KEYW);
  assign scrFire  = (state == S_EMIT) && (cls == C_SCR);
  assign err      = (state == S_EMIT) && emitBad;
  assign done     = ((state == S_EMIT) && !(cls == C_ALU1 && !emitBad)) || (state == S_TAIL);

  // R4
  lookup_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) lookupRd |=> !lookupRd);
  // R7
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (keyReq && !keyValid) |=> keyReq);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
endmodule

// File: rtl/numrw_datapath.sv
module numrw_datapath
  import numrw_pkg::*;
#(
  parameter int W = 8,
  localparam int NW = 5 + 3 * W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [NW-1:0] nodeA,
  input  logic [W-1:0]  addrA,
  input  logic [NW-1:0] nodeB,
  input  logic [W-1:0]  addrB,
  input  logic [NW-1:0] lookupNode,
  input  logic [W-1:0]  keyData,
  output pair_e         cls,
  output logic          argOk,
  output logic [W-1:0]  lookupAddr,
  output logic [W-1:0]  scrValue,
  output logic          wr0Vld,
  output logic [W-1:0]  wr0Addr,
  output logic [NW-1:0] wr0Node,
  output logic          wr1Vld,
  output logic [W-1:0]  wr1Addr,
  output logic [NW-1:0] wr1Node
);
  function automatic logic [3:0] kindOf(input logic [NW-1:0] n); return n[NW-1 -: 4]; endfunction
  function automatic logic flagOf(input logic [NW-1:0] n); return n[3*W]; endfunction
  function automatic logic [W-1:0] prinOf(input logic [NW-1:0] n); return n[3*W-1 -: W]; endfunction
  function automatic logic [W-1:0] aux1Of(input logic [NW-1:0] n); return n[2*W-1 -: W]; endfunction
  function automatic logic [W-1:0] aux2Of(input logic [NW-1:0] n); return n[W-1:0]; endfunction
  function automatic logic [NW-1:0] mkNode(input logic [3:0] k, input logic f,
                                           input logic [W-1:0] p, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    return {k, f, p, a, b};
  endfunction

  logic [NW-1:0] opNode, parNode, argNode;
  logic [W-1:0]  opAddr, parAddr, keyReg;
  logic          swapSel, parIsNum, isZero;
  kind_e         kA, kB, opK, parK;
  logic [W-1:0]  argVal, parVal, sumVal, prodVal, aluOut, chosen, dropped;

  assign kA      = kind_e'(kindOf(nodeA));
  assign kB      = kind_e'(kindOf(nodeB));
  assign swapSel = (kA == K_NUM) || (kB == K_KEY && kA != K_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opNode <= '0; parNode <= '0; argNode <= '0;
      opAddr <= '0; parAddr <= '0; keyReg <= '0;
    end else begin
      if (stb.loadPair) begin
        opNode  <= swapSel ? nodeB : nodeA;
        opAddr  <= swapSel ? addrB : addrA;
        parNode <= swapSel ? nodeA : nodeB;
        parAddr <= swapSel ? addrA : addrB;
      end
      if (stb.loadArg) argNode <= lookupNode;
      if (stb.loadKey) keyReg <= keyData;
    end
  end

  assign opK      = kind_e'(kindOf(opNode));
  assign parK     = kind_e'(kindOf(parNode));
  assign parIsNum = (parK == K_NUM) && !flagOf(parNode);

  always_comb begin
    unique case (opK)
      K_ADD0, K_MUL0: cls = parIsNum ? C_ALU0 : C_ERR;
      K_ADD1, K_MUL1: cls = parIsNum ? C_ALU1 : C_ERR;
      K_IF0:          cls = parIsNum ? C_IF0 : C_ERR;
      K_SCR:          cls = parIsNum ? C_SCR : C_ERR;
      K_KEY:          cls = (parK inside {K_ADD0, K_ADD1, K_MUL0, K_MUL1, K_IF0, K_SCR}) ? C_KEY : C_ERR;
      default:        cls = C_ERR;
    endcase
  end

  assign argOk      = (kindOf(argNode) == K_NUM) && !flagOf(argNode);
  assign lookupAddr = aux2Of(opNode);
  assign argVal     = aux2Of(argNode);
  assign parVal     = aux2Of(parNode);
  assign scrValue   = parVal;
  assign sumVal     = argVal + parVal;
  assign prodVal    = argVal * parVal;
  assign aluOut     = (opK == K_MUL1) ? prodVal : sumVal;
  assign isZero     = (parVal == '0);
  assign chosen     = isZero ? aux1Of(opNode) : aux2Of(opNode);
  assign dropped    = isZero ? aux2Of(opNode) : aux1Of(opNode);

  always_comb begin
    wr0Vld = 1'b0; wr0Addr = '0; wr0Node = '0;
    wr1Vld = 1'b0; wr1Addr = '0; wr1Node = '0;
    if (stb.emit) begin
      unique case (cls)
        C_ALU0: begin
          wr0Vld  = 1'b1; wr0Addr = opAddr;
          wr0Node = mkNode((opK == K_MUL0) ? K_MUL1 : K_ADD1, 1'b1,
                           aux2Of(opNode), aux1Of(opNode), prinOf(opNode));
        end
        C_ALU1: begin
          wr0Vld = 1'b1; wr0Addr = opAddr; wr0Node = mkNode(K_NUM, 1'b0, aux1Of(opNode), '0, aluOut);
          wr1Vld = 1'b1; wr1Addr = parAddr;
        end
        C_IF0: begin
          wr0Vld = 1'b1; wr0Addr = opAddr;  wr0Node = mkNode(K_ERA, 1'b0, dropped, '0, '0);
          wr1Vld = 1'b1; wr1Addr = parAddr; wr1Node = mkNode(K_NUM, 1'b0, chosen, '0, parVal);
        end
        C_SCR: begin
          wr0Vld = 1'b1; wr0Addr = opAddr;
          wr1Vld = 1'b1; wr1Addr = parAddr;
        end
        C_KEY: begin
          wr0Vld = 1'b1; wr0Addr = opAddr; wr0Node = mkNode(K_NUM, 1'b0, prinOf(opNode), '0, keyReg);
        end
        default: ;
      endcase
    end
    if (stb.emitTail) begin
      wr0Vld = 1'b1; wr0Addr = aux2Of(opNode);
    end
  end

  // R11
  wr_order_chk: assert property (@(posedge clk) disable iff (!rstN) wr1Vld |-> wr0Vld);
  // R4
  tail_follows_chk: assert property (@(posedge clk) disable iff (!rstN) stb.emitTail |-> $past(stb.emit));
endmodule

// File: rtl/num_node_rewriter.sv
module num_node_rewriter
  import numrw_pkg::*;
#(
  parameter int W = 8,
  localparam int NW = 5 + 3 * W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [NW-1:0] nodeA,
  input  logic [W-1:0]  addrA,
  input  logic [NW-1:0] nodeB,
  input  logic [W-1:0]  addrB,
  output logic          busy,
  output logic          lookupRd,
  output logic [W-1:0]  lookupAddr,
  input  logic [NW-1:0] lookupNode,
  output logic          keyReq,
  input  logic          keyValid,
  input  logic [W-1:0]  keyData,
  output logic          scrFire,
  output logic [W-1:0]  scrValue,
  output logic          wr0Vld,
  output logic [W-1:0]  wr0Addr,
  output logic [NW-1:0] wr0Node,
  output logic          wr1Vld,
  output logic [W-1:0]  wr1Addr,
  output logic [NW-1:0] wr1Node,
  output logic          done,
  output logic          err
);
  strobe_t stb;
  pair_e   cls;
  logic    argOk;

  numrw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cls(cls), .argOk(argOk), .keyValid(keyValid),
    .stb(stb), .busy(busy), .lookupRd(lookupRd), .keyReq(keyReq), .scrFire(scrFire),
    .done(done), .err(err)
  );

  numrw_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nodeA(nodeA), .addrA(addrA), .nodeB(nodeB),
    .addrB(addrB), .lookupNode(lookupNode), .keyData(keyData), .cls(cls), .argOk(argOk),
    .lookupAddr(lookupAddr), .scrValue(scrValue), .wr0Vld(wr0Vld), .wr0Addr(wr0Addr),
    .wr0Node(wr0Node), .wr1Vld(wr1Vld), .wr1Addr(wr1Addr), .wr1Node(wr1Node)
  );

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) err |-> (!wr0Vld && !wr1Vld));
  // R8
  scr_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    scrFire |-> (wr0Vld && wr1Vld && wr0Node == '0 && wr1Node == '0));
  // R4
  lookup_no_done_chk: assert property (@(posedge clk) disable iff (!rstN) lookupRd |=> !done);
endmodule

// File: tb/num_node_rewriter_tb.sv
module num_node_rewriter_tb;
  localparam int W  = 4;
  localparam int NW = 5 + 3 * W;
  localparam logic [3:0] KNUM = 1, KADD0 = 2, KADD1 = 3, KMUL0 = 4, KMUL1 = 5,
                         KIF0 = 6, KKEY = 7, KSCR = 8, KERA = 9, KCON = 11;

  logic clk = 0, rstN = 0, start = 0, keyValid = 0;
  logic [NW-1:0] nodeA = '0, nodeB = '0, lookupNode = '0;
  logic [W-1:0]  addrA = '0, addrB = '0, keyData = '0;
  logic busy, lookupRd, keyReq, scrFire, wr0Vld, wr1Vld, done, err;
  logic [W-1:0] lookupAddr, scrValue, wr0Addr, wr1Addr;
  logic [NW-1:0] wr0Node, wr1Node;

  num_node_rewriter #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .nodeA(nodeA), .addrA(addrA), .nodeB(nodeB),
    .addrB(addrB), .busy(busy), .lookupRd(lookupRd), .lookupAddr(lookupAddr),
    .lookupNode(lookupNode), .keyReq(keyReq), .keyValid(keyValid), .keyData(keyData),
    .scrFire(scrFire), .scrValue(scrValue), .wr0Vld(wr0Vld), .wr0Addr(wr0Addr),
    .wr0Node(wr0Node), .wr1Vld(wr1Vld), .wr1Addr(wr1Addr), .wr1Node(wr1Node),
    .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int nTests = 0, nFail = 0;
  logic [NW-1:0] mem [16];
  int nBeats, doneSeen, errSeen, scrSeen, lookSeen, extra;
  logic [W-1:0] scrVal, lookAddr, keyVal;
  logic b0v [4], b1v [4];
  logic [W-1:0] b0a [4], b1a [4];
  logic [NW-1:0] b0n [4], b1n [4];

  function automatic logic [NW-1:0] mk(input logic [3:0] k, input logic f, input int p,
                                       input int a, input int b);
    return {k, f, p[W-1:0], a[W-1:0], b[W-1:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [NW-1:0] a, input int aa, input logic [NW-1:0] b, input int ba,
                       input int kdelay, input bit poke);
    int kc;
    bit fin;
    kc = 0; fin = 0; nBeats = 0; doneSeen = 0; errSeen = 0; scrSeen = 0; lookSeen = 0; extra = 0;
    for (int j = 0; j < 4; j++) begin b0v[j] = 0; b1v[j] = 0; end
    @(negedge clk);
    nodeA = a; addrA = aa[W-1:0]; nodeB = b; addrB = ba[W-1:0]; start = 1;
    @(negedge clk);
    start = poke;
    if (poke) begin nodeA = mk(KSCR, 1, 1, 1, 1); nodeB = mk(KNUM, 0, 1, 0, 9); end
    for (int i = 0; i < 40; i++) begin
      if (i == 1) start = 0;
      keyValid = 0;
      if (keyReq) begin
        if (kc == kdelay) begin keyValid = 1; keyData = keyVal; end
        kc++;
      end
      if (lookupRd) begin lookSeen++; lookAddr = lookupAddr; lookupNode = mem[lookupAddr]; end
      if (scrFire) begin scrSeen++; scrVal = scrValue; end
      if (wr0Vld || wr1Vld) begin
        if (nBeats < 4) begin
          b0v[nBeats] = wr0Vld; b0a[nBeats] = wr0Addr; b0n[nBeats] = wr0Node;
          b1v[nBeats] = wr1Vld; b1a[nBeats] = wr1Addr; b1n[nBeats] = wr1Node;
        end
        nBeats++;
      end
      if (err) errSeen++;
      if (done) begin doneSeen++; fin = 1; end
      @(negedge clk);
      if (fin) break;
    end
    start = 0;
    for (int i = 0; i < 3; i++) begin
      if (wr0Vld || wr1Vld || done) extra++;
      @(negedge clk);
    end
    // R11: one done pulse, nothing afterwards
    check(doneSeen == 1 && extra == 0, "R11 single done", doneSeen + extra, 1);
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    keyVal = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err && !wr0Vld && !wr1Vld && !lookupRd && !keyReq && !scrFire,
          "R1 reset outputs", {busy, done, err, wr0Vld, wr1Vld, lookupRd, keyReq, scrFire}, 0);
    rstN = 1;

    // R3 / R2: first-argument swap, both orders, both operators
    for (int op = 0; op < 2; op++)
      for (int l = 0; l < 16; l++)
        for (int ord = 0; ord < 2; ord++) begin
          logic [3:0] k0, k1;
          logic [NW-1:0] opn, num;
          k0 = op ? KMUL0 : KADD0; k1 = op ? KMUL1 : KADD1;
          opn = mk(k0, 1, l, (l + 5) % 16, (l + 9) % 16);
          num = mk(KNUM, 0, l, 0, 7);
          if (ord == 0) issue(opn, 4, num, 11, 0, 0); else issue(num, 11, opn, 4, 0, 0);
          check(nBeats == 1 && b0v[0] && !b1v[0] && b0a[0] == 4, "R3 swap slot", nBeats, 1);
          check(b0n[0] == mk(k1, 1, (l + 9) % 16, (l + 5) % 16, l), "R2 R3 swapped node", b0n[0],
                mk(k1, 1, (l + 9) % 16, (l + 5) % 16, l));
        end

    // R4: exhaustive second-argument arithmetic
    for (int op = 0; op < 2; op++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++) begin
          int r;
          mem[6] = mk(KNUM, 0, 3, 0, x);
          r = op ? (x * y) % 16 : (x + y) % 16;
          issue(mk(op ? KMUL1 : KADD1, 1, 2, 1, 6), 4, mk(KNUM, 0, 2, 0, y), 9, 0, 0);
          check(lookSeen == 1 && lookAddr == 6, "R4 lookup addr", lookAddr, 6);
          check(nBeats == 2 && b0v[0] && b1v[0] && b0a[0] == 4 && b1a[0] == 9 && b1n[0] == '0,
                "R4 beat one slots", nBeats, 2);
          check(b0n[0] == mk(KNUM, 0, 1, 0, r), "R4 result", b0n[0], mk(KNUM, 0, 1, 0, r));
          check(b0v[1] && !b1v[1] && b0a[1] == 6 && b0n[1] == '0, "R4 free first operand", b0a[1], 6);
        end

    // R5: looked-up node not a number
    mem[6] = mk(KCON, 1, 1, 2, 3);
    issue(mk(KADD1, 1, 2, 1, 6), 4, mk(KNUM, 0, 2, 0, 3), 9, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R5 bad operand", {errSeen[3:0], nBeats[3:0]}, 8'h10);

    // R6: zero test for every value
    for (int v = 0; v < 16; v++) begin
      int ch, dr;
      ch = (v == 0) ? 7 : 11; dr = (v == 0) ? 11 : 7;
      issue(mk(KNUM, 0, 2, 0, v), 5, mk(KIF0, 1, 2, 7, 11), 3, 0, 0);
      check(nBeats == 1 && b0a[0] == 3 && b0n[0] == mk(KERA, 0, dr, 0, 0), "R6 eraser", b0n[0],
            mk(KERA, 0, dr, 0, 0));
      check(b1v[0] && b1a[0] == 5 && b1n[0] == mk(KNUM, 0, ch, 0, v), "R6 forward", b1n[0],
            mk(KNUM, 0, ch, 0, v));
    end

    // R7: key against each number-expecting kind, several delays
    for (int pk = 0; pk < 6; pk++)
      for (int d = 0; d < 4; d++) begin
        logic [3:0] pks [6];
        pks = '{KADD0, KADD1, KMUL0, KMUL1, KIF0, KSCR};
        keyVal = (pk * 4 + d + 3) % 16;
        issue(mk(pks[pk], 1, 12, 1, 2), 3, mk(KKEY, 1, 12, 0, 0), 8, d, 0);
        check(nBeats == 1 && b0v[0] && !b1v[0] && b0a[0] == 8, "R7 key slot", b0a[0], 8);
        check(b0n[0] == mk(KNUM, 0, 12, 0, keyVal), "R7 key value", b0n[0], mk(KNUM, 0, 12, 0, keyVal));
      end

    // R8: screen consumes each value
    for (int v = 0; v < 16; v++) begin
      issue(mk(KNUM, 0, 4, 0, v), 7, mk(KSCR, 1, 4, 0, 0), 2, 0, 0);
      check(scrSeen == 1 && scrVal == v, "R8 pixel value", scrVal, v);
      check(nBeats == 1 && b0a[0] == 2 && b1a[0] == 7 && b0n[0] == '0 && b1n[0] == '0,
            "R8 slots emptied", {b0a[0], b1a[0]}, 8'h27);
    end

    // R9: unsupported pairs
    issue(mk(KNUM, 0, 1, 0, 3), 1, mk(KNUM, 0, 1, 0, 4), 2, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R9 num num", errSeen, 1);
    issue(mk(KKEY, 1, 1, 0, 0), 1, mk(KKEY, 1, 1, 0, 0), 2, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R9 key key", errSeen, 1);
    issue(mk(KKEY, 1, 1, 0, 0), 1, mk(KNUM, 0, 1, 0, 4), 2, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R9 key num", errSeen, 1);
    issue(mk(KCON, 1, 1, 2, 3), 1, mk(KNUM, 0, 1, 0, 4), 2, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R9 unknown kind", errSeen, 1);
    issue(mk(KADD0, 1, 1, 2, 3), 1, mk(KNUM, 1, 1, 0, 4), 2, 0, 0);
    check(errSeen == 1 && nBeats == 0, "R9 flagged num", errSeen, 1);

    // R10: start while busy is ignored
    issue(mk(KADD0, 1, 3, 1, 2), 4, mk(KNUM, 0, 3, 0, 7), 11, 0, 1);
    check(nBeats == 1 && errSeen == 0 && scrSeen == 0 && b0n[0] == mk(KADD1, 1, 2, 1, 3),
          "R10 busy start ignored", b0n[0], mk(KADD1, 1, 2, 1, 3));

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule